// File: doc/BRIEF.md
# Burst-of-Two Common-I/O SRAM Core

This block is a synchronous memory with a narrow data bus. Every command moves two beats. Inside, each array word is twice as wide as one beat. A write gathers two beats, with their byte enables, into one double-width word and stores it in a single array write. A read fetches one double-width word and returns it as two consecutive beats, together with a valid flag. The word address is one bit narrower than a beat-level address would be, because each address names a pair of beats. The two clock edges of a double-data-rate bus are modelled as two consecutive cycles of one system clock.

A four-state slot machine sequences the commands.
- **S_IDLE** accepts a command when `cmd_ld` is high. It moves to S_WR_LO for a write or to S_RD_TAIL for a read, and stays in S_IDLE otherwise.
- **S_WR_LO** takes the low write beat, ignores `cmd_ld` and always moves to S_WR_HI.
- **S_WR_HI** takes the high write beat and commits the word. It also accepts a new command, with the same transitions as S_IDLE.
- **S_RD_TAIL** is the second slot of a read. It ignores `cmd_ld` and always returns to S_IDLE.

Writes are late writes: the data follows the command. A read accepted in the same cycle that a write's high beat arrives is served through a forwarding path, so it returns the new bytes.

Top module: `b2_sram_core`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `rd_valid` is 0 and `rd_data` is 0.
- R2: A cycle in S_IDLE or S_WR_HI with `cmd_ld` low is a no-operation. Read data does not appear, and no stored word changes, whatever the other inputs carry.
- R3: Each command occupies two cycles. In the cycle after an accepted command, `cmd_ld` is ignored, so a command presented there neither reads nor writes.
- R4: A write accepted in cycle T takes `wr_data` in cycle T+1 as the low half (word bits [BEAT_W-1:0]) and in cycle T+2 as the high half (word bits [2*BEAT_W-1:BEAT_W]). It stores both halves into the word at `cmd_addr` in a single update.
- R5: `wr_be` is sampled with each beat, not with the command. Bit i covers `wr_data[8i+7:8i]`, and a cleared bit leaves that byte of the stored word unchanged.
- R6: A read accepted in cycle T puts the low half of the word on `rd_data` in cycle T+2 and the high half in cycle T+3. `rd_valid` is 1 in exactly those two cycles.
- R7: `rd_data` is 0 in every cycle where `rd_valid` is 0.
- R8: A read accepted in the cycle that carries the high beat of a write to the same address returns the word as that write leaves it. Masked bytes keep their old values.
- R9: Commands may be issued every second cycle without a gap. Consecutive reads then give an unbroken stream of `rd_valid` beats.
- R10: Each of the 2**ADDR_W addresses selects its own double-width word, including address 0 and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each cycle is one beat slot |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ld | input | 1 | Load strobe; a command is taken when high in an accepting cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address of the double-width word |
| wr_data | input | BEAT_W | Write beat |
| wr_be | input | BEAT_W/8 | Byte enables sampled with each write beat |
| rd_data | output | BEAT_W | Read beat; zero when not valid |
| rd_valid | output | 1 | High during the two beats of read data |

## Verification
The bench goes after the cycle in which a write's high beat coincides with a new read to the same address. A design without forwarding would return the old word there, and one that merged the masks wrongly would corrupt the masked bytes. It presents commands in the ignored second slot after both reads and writes. A design that accepted them would emit stray `rd_valid` beats or overwrite a word. It checks that the low half comes out first, with exactly two cycles of latency. A swapped half, or a latency off by one, shows up as a mismatch on every read. It also runs reads back to back, to catch a read pipeline that lets one burst clobber the next.

// File: rtl/b2_pkg.sv
`timescale 1ns/1ps
package b2_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WR_LO   = 2'd1,
        S_WR_HI   = 2'd2,
        S_RD_TAIL = 2'd3
    } slot_state_t;
endpackage

// File: rtl/b2_cmd_fsm.sv
`timescale 1ns/1ps
module b2_cmd_fsm
    import b2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_ld,
    input  logic cmd_wr,
    output logic acc_wr,
    output logic acc_rd,
    output logic cap_lo,
    output logic cap_hi
);
    slot_state_t state_q, state_d;
    logic        can_accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_WR_HI: begin
                if (cmd_ld) state_d = cmd_wr ? S_WR_LO : S_RD_TAIL;
                else        state_d = S_IDLE;
            end
            S_WR_LO:   state_d = S_WR_HI;
            S_RD_TAIL: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        can_accept = (state_q == S_IDLE) || (state_q == S_WR_HI);
        acc_wr     = can_accept && cmd_ld && cmd_wr;
        acc_rd     = can_accept && cmd_ld && !cmd_wr;
        cap_lo     = (state_q == S_WR_LO);
        cap_hi     = (state_q == S_WR_HI);
    end

    // R4
    wr_lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_LO) |=> (state_q == S_WR_HI));

    // R3
    rd_tail_ignores_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_TAIL) |=> (state_q == S_IDLE));
endmodule

// File: rtl/b2_write_gather.sv
`timescale 1ns/1ps
module b2_write_gather #(
    parameter int BEAT_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_wr,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [BEAT_W-1:0]     wr_data,
    input  logic [BEAT_W/8-1:0]   wr_be,
    output logic                  commit_en,
    output logic [ADDR_W-1:0]     commit_addr,
    output logic [2*BEAT_W-1:0]   commit_word,
    output logic [2*BEAT_W/8-1:0] commit_be
);
    localparam int LANES = BEAT_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] lo_data_q;
    logic [LANES-1:0]  lo_be_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            lo_data_q <= '0;
            lo_be_q   <= '0;
        end else begin
            if (acc_wr) addr_q <= cmd_addr;
            if (cap_lo) begin
                lo_data_q <= wr_data;
                lo_be_q   <= wr_be;
            end
        end
    end

    always_comb begin
        commit_en   = cap_hi;
        commit_addr = addr_q;
        commit_word = {wr_data, lo_data_q};
        commit_be   = {wr_be, lo_be_q};
    end

    // R4
    commit_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> $past(cap_lo));
endmodule

// File: rtl/b2_array.sv
`timescale 1ns/1ps
module b2_array #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [WORD_W-1:0]   wword,
    input  logic [WORD_W/8-1:0] wbe,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [WORD_W-1:0]   rword
);
    localparam int LANES = WORD_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[g]) lane_mem[waddr] <= wword[g*8 +: 8];
        end

        assign rword[g*8 +: 8] = lane_mem[raddr];
    end
endmodule

// File: rtl/b2_read_path.sv
`timescale 1ns/1ps
module b2_read_path #(
    parameter int BEAT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_rd,
    input  logic [2*BEAT_W-1:0]   arr_word,
    input  logic                  fwd_hit,
    input  logic [2*BEAT_W-1:0]   fwd_word,
    input  logic [2*BEAT_W/8-1:0] fwd_be,
    output logic [BEAT_W-1:0]     rd_data,
    output logic                  rd_valid
);
    localparam int WORD_W = 2 * BEAT_W;
    localparam int WLANES = WORD_W / 8;

    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic [BEAT_W-1:0] hi_q;
    logic              s1_q, s2_q;
    logic [BEAT_W-1:0] rdata_q;
    logic              rvalid_q;

    always_comb begin
        for (int i = 0; i < WLANES; i++) begin
            merged[i*8 +: 8] = (fwd_hit && fwd_be[i]) ? fwd_word[i*8 +: 8]
                                                      : arr_word[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            hi_q     <= '0;
            s1_q     <= 1'b0;
            s2_q     <= 1'b0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            s1_q <= acc_rd;
            s2_q <= s1_q;
            if (acc_rd) word_q <= merged;
            if (s1_q)   hi_q   <= word_q[WORD_W-1:BEAT_W];
            if (s1_q) begin
                rdata_q  <= word_q[BEAT_W-1:0];
                rvalid_q <= 1'b1;
            end else if (s2_q) begin
                rdata_q  <= hi_q;
                rvalid_q <= 1'b1;
            end else begin
                rdata_q  <= '0;
                rvalid_q <= 1'b0;
            end
        end
    end

    assign rd_data  = rdata_q;
    assign rd_valid = rvalid_q;

    // R6
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |-> ##2 rvalid_q);

    // R6
    rd_beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_q) |=> rvalid_q);

    // R9
    beat_stage_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q |-> !s2_q);

    // R7
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_q |-> (rdata_q == '0));
endmodule

// File: rtl/b2_sram_core.sv
`timescale 1ns/1ps
module b2_sram_core #(
    parameter int BEAT_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_ld,
    input  logic                cmd_wr,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [BEAT_W-1:0]   wr_data,
    input  logic [BEAT_W/8-1:0] wr_be,
    output logic [BEAT_W-1:0]   rd_data,
    output logic                rd_valid
);
    localparam int WORD_W = 2 * BEAT_W;
    localparam int WLANES = WORD_W / 8;

    logic              acc_wr, acc_rd, cap_lo, cap_hi;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0] commit_word;
    logic [WLANES-1:0] commit_be;
    logic [WORD_W-1:0] arr_word;
    logic              fwd_hit;

    b2_cmd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_ld (cmd_ld),
        .cmd_wr (cmd_wr),
        .acc_wr (acc_wr),
        .acc_rd (acc_rd),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi)
    );

    b2_write_gather #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr      (acc_wr),
        .cmd_addr    (cmd_addr),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_word (commit_word),
        .commit_be   (commit_be)
    );

    b2_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (commit_en),
        .waddr (commit_addr),
        .wword (commit_word),
        .wbe   (commit_be),
        .raddr (cmd_addr),
        .rword (arr_word)
    );

    assign fwd_hit = commit_en && (commit_addr == cmd_addr);

    b2_read_path #(.BEAT_W(BEAT_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .arr_word (arr_word),
        .fwd_hit  (fwd_hit),
        .fwd_word (commit_word),
        .fwd_be   (commit_be),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: tb/b2_sram_core_bench.sv
`timescale 1ns/1ps
module b2_sram_core_bench;
    localparam int BW = 16;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_ld = 1'b0, cmd_wr = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic [BW-1:0] rd_data;
    logic          rd_valid;

    int    n_checks = 0, n_fail = 0, cyc = 0;
    bit    checking = 0, done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    b2_sram_core #(.BEAT_W(BW), .ADDR_W(AW)) u_b2_sram_core (
        .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // behavioural reference model
    logic [31:0] m_mem [DEPTH];
    logic [BW-1:0] exp_d [int];
    int          busy = 0, wph = 0;
    logic [AW-1:0] wa;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; wph = 0;
        end else begin
            if (wph == 2) begin
                if (wr_be[0]) m_mem[wa][23:16] = wr_data[7:0];
                if (wr_be[1]) m_mem[wa][31:24] = wr_data[15:8];
                wph = 0;
            end else if (wph == 1) begin
                if (wr_be[0]) m_mem[wa][7:0]  = wr_data[7:0];
                if (wr_be[1]) m_mem[wa][15:8] = wr_data[15:8];
                wph = 2;
            end
            if (busy == 0 && cmd_ld) begin
                busy = 1;
                if (cmd_wr) begin
                    wph = 1; wa = cmd_addr;
                end else begin
                    exp_d[cyc+2] = m_mem[cmd_addr][15:0];
                    exp_d[cyc+3] = m_mem[cmd_addr][31:16];
                end
            end else begin
                busy = 0;
            end
        end
        cyc++;
    end

    always @(negedge clk) begin
        if (checking) begin
            logic          ev;
            logic [BW-1:0] ed;
            ev = exp_d.exists(cyc);
            ed = ev ? exp_d[cyc] : '0;
            n_checks++;
            if (rd_valid !== ev || rd_data !== ed) begin
                n_fail++;
                $display("FAIL %s cycle %0d: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                         cur_req, cyc, rd_valid, rd_data, ev, ed);
            end
        end
    end

    task automatic drive(input logic l, input logic w, input logic [AW-1:0] a,
                         input logic [BW-1:0] d, input logic [1:0] b);
        @(negedge clk);
        cmd_ld = l; cmd_wr = w; cmd_addr = a; wr_data = d; wr_be = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 16'h0, 2'b00);
    endtask

    function automatic logic [BW-1:0] pat(input int a, input int half);
        return BW'((a * 16'h0133) ^ (half ? 16'hC35A : 16'h5AC3));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        n_checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0) begin
            n_fail++;
            $display("FAIL R1 in reset: rd_valid=%0b rd_data=%h expected 0/0000", rd_valid, rd_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0) begin
            n_fail++;
            $display("FAIL R1 after reset: rd_valid=%0b rd_data=%h expected 0/0000", rd_valid, rd_data);
        end
        checking = 1;

        // R4 R10: fill every word with back-to-back writes
        cur_req = "R4";
        drive(1, 1, 0, 16'h0, 2'b00);
        for (int a = 0; a < DEPTH; a++) begin
            drive(0, 0, 0, pat(a, 0), 2'b11);
            drive(a < DEPTH - 1, 1, AW'(a + 1), pat(a, 1), 2'b11);
        end
        idle(2);

        // R6 R9 R10: back-to-back reads including both ends of the range
        cur_req = "R9";
        for (int a = 0; a < DEPTH; a += 7) begin
            drive(1, 0, AW'(a), 16'h0, 2'b00);
            drive(0, 0, 0, 16'h0, 2'b00);
        end
        cur_req = "R10";
        drive(1, 0, AW'(DEPTH - 1), 16'h0, 2'b00);
        drive(0, 0, 0, 16'h0, 2'b00);
        drive(1, 0, 0, 16'h0, 2'b00);
        idle(5);

        // R2: strobe low with write intent is a no-op
        cur_req = "R2";
        drive(0, 1, 5, 16'hDEAD, 2'b11);
        drive(0, 1, 5, 16'hBEEF, 2'b11);
        drive(0, 1, 5, 16'hF00D, 2'b11);
        drive(1, 0, 5, 16'h0, 2'b00);
        idle(5);

        // R3: commands in the second slot are ignored
        cur_req = "R3";
        drive(1, 1, 7, 16'h0, 2'b00);
        drive(1, 0, 8, 16'h7A7A, 2'b11);
        drive(0, 0, 0, 16'h7B7B, 2'b11);
        drive(1, 0, 9, 16'h0, 2'b00);
        drive(1, 1, 9, 16'hEEEE, 2'b11);
        drive(0, 1, 9, 16'hEEEE, 2'b11);
        idle(4);
        drive(1, 0, 7, 16'h0, 2'b00);
        drive(0, 0, 0, 16'h0, 2'b00);
        drive(1, 0, 9, 16'h0, 2'b00);
        idle(5);

        // R5: byte enables per beat
        cur_req = "R5";
        drive(1, 1, 12, 16'h0, 2'b00);
        drive(0, 0, 0, 16'hAB12, 2'b10);
        drive(0, 0, 0, 16'hCD34, 2'b01);
        drive(1, 0, 12, 16'h0, 2'b00);
        idle(5);

        // R8: read in the high-beat cycle of a write to the same word
        cur_req = "R8";
        drive(1, 1, 20, 16'h0, 2'b00);
        drive(0, 0, 0, 16'h1111, 2'b01);
        drive(1, 0, 20, 16'h2222, 2'b10);
        drive(0, 0, 0, 16'h0, 2'b00);
        drive(1, 1, 21, 16'h0, 2'b00);
        drive(0, 0, 0, 16'h3333, 2'b11);
        drive(1, 0, 22, 16'h4444, 2'b11);
        drive(0, 0, 0, 16'h0, 2'b00);
        drive(1, 0, 21, 16'h0, 2'b00);
        drive(0, 0, 0, 16'h0, 2'b00);
        drive(1, 0, 20, 16'h0, 2'b00);
        idle(5);

        // R6 R7: mixed traffic with gaps
        cur_req = "R6";
        drive(1, 0, 33, 16'h0, 2'b00);
        idle(3);
        drive(1, 1, 33, 16'h0, 2'b00);
        drive(0, 0, 0, 16'h9876, 2'b11);
        drive(0, 0, 0, 16'h5432, 2'b11);
        idle(1);
        cur_req = "R7";
        drive(1, 0, 33, 16'h0, 2'b00);
        idle(8);

        checking = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule